// File: doc/BRIEF.md
# Secure Register Range Clear Sequencer

This block carries out a secure-state command that zeroes a contiguous run of entries in a floating-point register file of 64 single-precision (32-bit) entries, paired into 32 double-precision (64-bit) slots. A command gives a starting index, an entry count and a flag that says whether the index and count are in singles or in doubles. The block first looks at the security, feature and enable inputs to decide whether the command is refused, skipped or faulted. If it is allowed, it converts the range to single-entry numbers, checks that the range is legal, trims it to the registers that are implemented, and issues one zeroing write per clock.

The register file is seen only as a write port. Each write names a pair slot and carries two half enables, and the write data is always zero. An odd starting entry costs one upper-half write. Every complete pair after it costs one full-slot write. A lone even entry left at the end costs one lower-half write. When the vector extension is present, a one-cycle pulse then clears the vector predicate register. A one-cycle completion pulse reports the outcome. A new command is accepted only while the block is idle.

Top module: `sreg_clear_seq`

## Requirements
- R1: When `cfg_secure` or `cfg_mainline` is 0, the command completes with status UNDEF (code 2). No register write and no predicate clear is made. This check takes priority over every other outcome, including the fault.
- R2: Otherwise the command completes as NOP (code 1) with no writes when `cfg_fp_or_vec` is 0. It also completes as NOP when `cfg_lazy_en` is 1 and `cfg_fp_active` is 0.
- R3: Otherwise, when `cfg_fp_enabled` is 0, the command completes as FAULT (code 3) with no writes. This check comes before the range legality check.
- R4: In single mode (`cmd_dbl`=0) the range is entries base to base+count-1. In double mode it is entries 2*base to 2*(base+count)-1. Exactly these singles become zero and all other entries keep their values.
- R5: With a nonzero count, a last entry above 63, or above 31 and even, gives UNDEF (code 2) with no writes.
- R6: When `cfg_upper_d` is 0, a last entry above 31 is silently trimmed to 31. A count of 0, or a start at or beyond the trimmed end, gives status DONE with no writes.
- R7: Writes go in ascending slot order, one per cycle. `rf_half_en` bit 0 zeroes single 2*slot and bit 1 zeroes single 2*slot+1. An odd start writes 2'b10 first, whole pairs write 2'b11, and a lone even last entry writes 2'b01 last. The number of writes is the minimum this scheme allows.
- R8: A command that reaches DONE (code 0) with `cfg_vec`=1 pulses `pred_clr` for one cycle, directly after the last write and directly before completion. With `cfg_vec`=0 there is no pulse.
- R9: `done_valid` is a one-cycle pulse. It comes N+P+1 cycles after the accepting edge, where N is the write count and P is 1 if the predicate is cleared and 0 otherwise.
- R10: `cmd_ready` is low and `busy` is high from acceptance until completion. A command held on the input during that time has no effect.
- R11: After reset, `cmd_ready` is high and `busy`, `rf_we`, `pred_clr` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken at this edge |
| cmd_base | input | 6 | Starting register index |
| cmd_count | input | 7 | Number of registers |
| cmd_dbl | input | 1 | 1: index and count are in doubles |
| cfg_secure | input | 1 | Command issued from secure state |
| cfg_mainline | input | 1 | Mainline feature set present |
| cfg_fp_or_vec | input | 1 | Floating-point or vector support present |
| cfg_vec | input | 1 | Vector extension present |
| cfg_upper_d | input | 1 | Upper 16 doubles implemented |
| cfg_lazy_en | input | 1 | Automatic state preservation enabled |
| cfg_fp_active | input | 1 | Secure floating-point context active |
| cfg_fp_enabled | input | 1 | Floating-point access currently allowed |
| busy | output | 1 | Command in progress |
| rf_we | output | 1 | Zeroing write this cycle |
| rf_pair | output | 5 | Pair slot written |
| rf_half_en | output | 2 | Half enables (bit 0 low single, bit 1 high single) |
| pred_clr | output | 1 | Clear the vector predicate register |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 2 | 0 DONE, 1 NOP, 2 UNDEF, 3 FAULT |

## Verification
Refused, skipped and faulted commands complete one cycle after the accepting edge. A clearing command shows its first write one cycle after acceptance, then one write per cycle, then the optional predicate pulse, then completion. The bench drives inputs on falling edges and applies each write to its own model of the register file on the falling edge, once per cycle. It counts falling edges from acceptance to the completion pulse and compares that count with N+P+1 from its own range model. Register contents, write count and predicate state are compared only after completion, when every write has landed.

// File: rtl/sclr_pkg.sv
package sclr_pkg;
    typedef enum logic [1:0] {
        ST_DONE  = 2'd0,
        ST_NOP   = 2'd1,
        ST_UNDEF = 2'd2,
        ST_FAULT = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CLEAR,
        PH_PRED,
        PH_FIN
    } phase_e;
endpackage

// File: rtl/sclr_range.sv
module sclr_range #(
    parameter int NUM_SREG = 64,
    parameter int CNT_W    = 7,
    localparam int IDX_W   = $clog2(NUM_SREG)
) (
    input  logic [IDX_W-1:0] base_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dbl_i,
    input  logic             upper_ok_i,
    output logic             bad_o,
    output logic             empty_o,
    output logic [IDX_W:0]   bot_o,
    output logic [IDX_W:0]   end_o
);
    localparam int EXT_W = IDX_W + CNT_W + 2;
    localparam logic [EXT_W-1:0] FULL = EXT_W'(NUM_SREG);
    localparam logic [EXT_W-1:0] HALF = EXT_W'(NUM_SREG / 2);

    logic [EXT_W-1:0] bot_ext;
    logic [EXT_W-1:0] end_ext;
    logic [EXT_W-1:0] end_trim;
    logic             no_count;

    always_comb begin
        // end_ext is one past the last single entry of the range
        bot_ext  = EXT_W'(base_i) << dbl_i;
        end_ext  = (EXT_W'(base_i) + EXT_W'(count_i)) << dbl_i;
        no_count = (count_i == '0);
        bad_o    = !no_count && ((end_ext > FULL) || ((end_ext > HALF) && end_ext[0]));
        end_trim = (!upper_ok_i && (end_ext > HALF)) ? HALF : end_ext;
        empty_o  = no_count || (bot_ext >= end_trim);
        bot_o    = bot_ext[IDX_W:0];
        end_o    = end_trim[IDX_W:0];
    end
endmodule

// File: rtl/sclr_gate.sv
module sclr_gate
    import sclr_pkg::*;
(
    input  logic    secure_i,
    input  logic    mainline_i,
    input  logic    fp_or_vec_i,
    input  logic    lazy_en_i,
    input  logic    fp_active_i,
    input  logic    fp_enabled_i,
    input  logic    range_bad_i,
    output status_e status_o,
    output logic    go_o
);
    always_comb begin
        if (!secure_i || !mainline_i) begin
            status_o = ST_UNDEF;
        end else if (!fp_or_vec_i || (lazy_en_i && !fp_active_i)) begin
            status_o = ST_NOP;
        end else if (!fp_enabled_i) begin
            status_o = ST_FAULT;
        end else if (range_bad_i) begin
            status_o = ST_UNDEF;
        end else begin
            status_o = ST_DONE;
        end
        go_o = (status_o == ST_DONE);
    end
endmodule

// File: rtl/sclr_step.sv
module sclr_step #(
    parameter int NUM_SREG = 64,
    localparam int IDX_W   = $clog2(NUM_SREG)
) (
    input  logic [IDX_W:0]   cur_i,
    input  logic [IDX_W:0]   end_i,
    output logic [IDX_W-2:0] pair_o,
    output logic [1:0]       half_en_o,
    output logic [IDX_W:0]   nxt_o,
    output logic             last_o
);
    logic [IDX_W:0] cur_p2;

    always_comb begin
        cur_p2 = cur_i + (IDX_W+1)'(2);
        pair_o = cur_i[IDX_W-1:1];
        if (cur_i[0]) begin
            half_en_o = 2'b10;
        end else if (cur_p2 <= end_i) begin
            half_en_o = 2'b11;
        end else begin
            half_en_o = 2'b01;
        end
        nxt_o  = (half_en_o == 2'b11) ? cur_p2 : cur_i + (IDX_W+1)'(1);
        last_o = (nxt_o >= end_i);
    end
endmodule

// File: rtl/sreg_clear_seq.sv
module sreg_clear_seq
    import sclr_pkg::*;
#(
    parameter int NUM_SREG = 64,
    parameter int CNT_W    = 7,
    localparam int IDX_W   = $clog2(NUM_SREG),
    localparam int PAIR_W  = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [IDX_W-1:0]  cmd_base,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_dbl,
    input  logic              cfg_secure,
    input  logic              cfg_mainline,
    input  logic              cfg_fp_or_vec,
    input  logic              cfg_vec,
    input  logic              cfg_upper_d,
    input  logic              cfg_lazy_en,
    input  logic              cfg_fp_active,
    input  logic              cfg_fp_enabled,
    output logic              busy,
    output logic              rf_we,
    output logic [PAIR_W-1:0] rf_pair,
    output logic [1:0]        rf_half_en,
    output logic              pred_clr,
    output logic              done_valid,
    output logic [1:0]        done_status
);
    typedef struct packed {
        phase_e         phase;
        logic [IDX_W:0] cur;
        logic [IDX_W:0] endx;
        logic           pred_en;
        status_e        status;
    } seq_t;

    seq_t st_d, st_q;

    logic           r_bad, r_empty;
    logic [IDX_W:0] r_bot, r_end;
    status_e        g_status;
    logic           g_go;
    logic [IDX_W:0] s_nxt;
    logic           s_last;

    sclr_range #(.NUM_SREG(NUM_SREG), .CNT_W(CNT_W)) u_range (
        .base_i     (cmd_base),
        .count_i    (cmd_count),
        .dbl_i      (cmd_dbl),
        .upper_ok_i (cfg_upper_d),
        .bad_o      (r_bad),
        .empty_o    (r_empty),
        .bot_o      (r_bot),
        .end_o      (r_end)
    );

    sclr_gate u_gate (
        .secure_i     (cfg_secure),
        .mainline_i   (cfg_mainline),
        .fp_or_vec_i  (cfg_fp_or_vec),
        .lazy_en_i    (cfg_lazy_en),
        .fp_active_i  (cfg_fp_active),
        .fp_enabled_i (cfg_fp_enabled),
        .range_bad_i  (r_bad),
        .status_o     (g_status),
        .go_o         (g_go)
    );

    sclr_step #(.NUM_SREG(NUM_SREG)) u_step (
        .cur_i     (st_q.cur),
        .end_i     (st_q.endx),
        .pair_o    (rf_pair),
        .half_en_o (rf_half_en),
        .nxt_o     (s_nxt),
        .last_o    (s_last)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    st_d.status  = g_status;
                    st_d.pred_en = cfg_vec;
                    st_d.cur     = r_bot;
                    st_d.endx    = r_end;
                    if (g_go && !r_empty) begin
                        st_d.phase = PH_CLEAR;
                    end else if (g_go && cfg_vec) begin
                        st_d.phase = PH_PRED;
                    end else begin
                        st_d.phase = PH_FIN;
                    end
                end
            end
            PH_CLEAR: begin
                st_d.cur = s_nxt;
                if (s_last) begin
                    st_d.phase = st_q.pred_en ? PH_PRED : PH_FIN;
                end
            end
            PH_PRED: st_d.phase = PH_FIN;
            PH_FIN:  st_d.phase = PH_IDLE;
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cur: '0, endx: '0, pred_en: 1'b0, status: ST_DONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready   = (st_q.phase == PH_IDLE);
    assign busy        = (st_q.phase != PH_IDLE);
    assign rf_we       = (st_q.phase == PH_CLEAR);
    assign pred_clr    = (st_q.phase == PH_PRED);
    assign done_valid  = (st_q.phase == PH_FIN);
    assign done_status = st_q.status;
endmodule

// File: rtl/sreg_clear_seq_chk.sv
module sreg_clear_seq_chk #(
    parameter int PAIR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              busy,
    input logic              rf_we,
    input logic [PAIR_W-1:0] rf_pair,
    input logic [1:0]        rf_half_en,
    input logic              pred_clr,
    input logic              done_valid,
    input logic [1:0]        done_status
);
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (busy && !cmd_ready)) else $error("write outside busy"); // R10

    AST_HALF_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_half_en != 2'b00)) else $error("empty half enable"); // R7

    AST_PAIR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && $past(rf_we)) |-> (rf_pair > $past(rf_pair))) else $error("slot order"); // R7

    AST_LOWER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_half_en == 2'b01) |=> !rf_we) else $error("lower half not last"); // R7

    AST_UPPER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_half_en == 2'b10) |-> !$past(rf_we)) else $error("upper half not first"); // R7

    AST_PRED_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pred_clr |=> (done_valid && done_status == 2'd0)) else $error("predicate order"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid) else $error("done not a pulse"); // R9

    AST_REFUSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_status != 2'd0) |-> (!$past(rf_we) && !$past(pred_clr)))
        else $error("refused command wrote"); // R1
endmodule

bind sreg_clear_seq sreg_clear_seq_chk #(.PAIR_W(PAIR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .busy        (busy),
    .rf_we       (rf_we),
    .rf_pair     (rf_pair),
    .rf_half_en  (rf_half_en),
    .pred_clr    (pred_clr),
    .done_valid  (done_valid),
    .done_status (done_status)
);

// File: tb/sreg_clear_seq_tb.sv
`timescale 1ns/1ps
module sreg_clear_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [5:0] cmd_base = '0;
    logic [6:0] cmd_count = '0;
    logic       cmd_dbl = 1'b0;
    logic [7:0] cfg = '0;
    logic       busy, rf_we, pred_clr, done_valid;
    logic [4:0] rf_pair;
    logic [1:0] rf_half_en, done_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wr_cnt = 0;
    logic [31:0] mem [64];
    logic [31:0] pre [64];
    logic [31:0] pred_m;

    always #2.5 clk = ~clk;

    // cfg = {secure, mainline, fp_or_vec, vec, upper_d, lazy_en, fp_active, fp_enabled}
    sreg_clear_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_count(cmd_count), .cmd_dbl(cmd_dbl),
        .cfg_secure(cfg[7]), .cfg_mainline(cfg[6]), .cfg_fp_or_vec(cfg[5]),
        .cfg_vec(cfg[4]), .cfg_upper_d(cfg[3]), .cfg_lazy_en(cfg[2]),
        .cfg_fp_active(cfg[1]), .cfg_fp_enabled(cfg[0]),
        .busy(busy), .rf_we(rf_we), .rf_pair(rf_pair), .rf_half_en(rf_half_en),
        .pred_clr(pred_clr), .done_valid(done_valid), .done_status(done_status)
    );

    // bench register file model, applied once per cycle on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rf_we) begin
                wr_cnt++;
                if (rf_half_en[0]) mem[2*rf_pair]   = '0;
                if (rf_half_en[1]) mem[2*rf_pair+1] = '0;
            end
            if (pred_clr) pred_m = '0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input int base, input int count, input bit dbl, input bit [7:0] c,
                         output int st, output int b, output int e);
        int ee;
        b  = dbl ? base * 2 : base;
        ee = dbl ? (base + count) * 2 : base + count;
        st = 0;
        if (!c[7] || !c[6]) st = 2;
        else if (!c[5] || (c[2] && !c[1])) st = 1;
        else if (!c[0]) st = 3;
        else if (count != 0 && (ee > 64 || (ee > 32 && (ee % 2) == 1))) st = 2;
        else begin
            if (!c[3] && ee > 32) ee = 32;
            if (count == 0) ee = b;
        end
        e = ee;
    endtask

    function automatic int nwrites(input int st, input int b, input int e);
        int b2;
        if (st != 0 || e <= b) return 0;
        b2 = b + (b % 2);
        return (b % 2) + (e - b2) / 2 + ((e - b2) % 2);
    endfunction

    task automatic run_cmd(input int base, input int count, input bit dbl, input bit [7:0] c,
                           input bit hold, input string req);
        int st, b, e, nw, pr, lat, bad;
        model(base, count, dbl, c, st, b, e);
        nw = nwrites(st, b, e);
        pr = (st == 0 && c[4]) ? 1 : 0;
        for (int i = 0; i < 64; i++) begin
            mem[i] = $urandom | 32'h1;
            pre[i] = mem[i];
        end
        pred_m = 32'hFFFF;
        wr_cnt = 0;
        @(negedge clk);
        cmd_base = 6'(base); cmd_count = 7'(count); cmd_dbl = dbl; cfg = c;
        cmd_valid = 1'b1;
        chk("R10", "ready when idle", cmd_ready, 1);
        @(negedge clk);
        if (hold) cmd_base = cmd_base ^ 6'h15;
        else cmd_valid = 1'b0;
        lat = 1;
        if (nw > 0) chk("R10", "busy and not ready", {busy, cmd_ready}, 2'b10);
        while (!done_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        cmd_valid = 1'b0;
        #1;
        chk(req, "status", done_status, st);
        chk("R9", "latency", lat, nw + pr + 1);
        chk("R7", "write count", wr_cnt, nw);
        chk("R8", "predicate", pred_m, pr ? 0 : 32'hFFFF);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (mem[i] !== ((st == 0 && i >= b && i < e) ? 32'h0 : pre[i])) bad++;
        end
        chk("R4", "register file mismatches", bad, 0);
        if (hold) begin
            repeat (4) @(negedge clk);
            chk("R10", "held command ignored", {wr_cnt, done_valid}, {nw, 1'b0});
        end
    endtask

    localparam bit [7:0] OK = 8'b1111_1011;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11", "reset outputs", {cmd_ready, busy, rf_we, pred_clr, done_valid}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "after release", {cmd_ready, busy, rf_we, done_valid}, 4'b1000);

        run_cmd(3, 4, 0, OK, 0, "R7");               // odd start, odd end
        run_cmd(4, 3, 0, OK, 0, "R7");               // even start, lone lower
        run_cmd(2, 3, 1, OK, 0, "R4");               // double mode
        run_cmd(14, 4, 1, OK & 8'b1111_0111, 0, "R6"); // trimmed at 32
        run_cmd(40, 2, 0, OK & 8'b1111_0111, 0, "R6"); // start past trim
        run_cmd(9, 0, 0, OK, 0, "R6");               // zero count
        run_cmd(30, 3, 0, OK, 0, "R5");              // top 32 even
        run_cmd(30, 3, 1, OK, 0, "R5");              // top 65
        run_cmd(31, 2, 0, OK, 0, "R4");              // top 32? no: 31..32 even top
        run_cmd(5, 6, 0, 8'b0111_1010, 0, "R1");     // non-secure beats fault
        run_cmd(5, 6, 0, 8'b1011_1011, 0, "R1");     // no mainline
        run_cmd(5, 6, 0, 8'b1101_1011, 0, "R2");     // no fp or vector
        run_cmd(5, 6, 0, 8'b1111_1101, 0, "R2");     // lazy, inactive
        run_cmd(5, 6, 0, 8'b1111_1010, 0, "R3");     // fault
        run_cmd(30, 3, 0, 8'b1111_1010, 0, "R3");    // fault before range
        run_cmd(0, 32, 1, OK, 0, "R4");              // whole file
        run_cmd(1, 5, 0, OK & 8'b1110_1111, 0, "R8"); // no vector, no pulse
        run_cmd(6, 5, 0, OK, 1, "R10");              // held while busy

        for (int n = 0; n < 400; n++) begin
            bit [7:0] c;
            bit dbl;
            int base, count;
            c = OK;
            if ($urandom % 10 == 0) c[7] = 1'b0;
            if ($urandom % 12 == 0) c[6] = 1'b0;
            if ($urandom % 12 == 0) c[5] = 1'b0;
            c[4] = $urandom % 2;
            c[3] = $urandom % 2;
            c[2] = $urandom % 2;
            c[1] = ($urandom % 5) != 0;
            if ($urandom % 10 == 0) c[0] = 1'b0;
            dbl   = $urandom % 2;
            base  = dbl ? $urandom % 34 : $urandom % 64;
            count = ($urandom % 8 == 0) ? $urandom % 128 : $urandom % 24;
            run_cmd(base, count, dbl, c, 0, "R4");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule